// File: doc/BRIEF.md
# Four-Phase Handshake Clock-Domain Word Transfer

This block carries one multi-bit word at a time from a source clock domain into an unrelated destination clock domain. The source offers a word on a valid/ready interface. Once the word is accepted, the block parks it in a holding register and raises a request level. The destination resynchronizes that level, captures the parked word, emits it with a one-cycle valid strobe, and raises an acknowledge level. The acknowledge travels back through its own synchronizer. The source then drops its request, and the destination drops its acknowledge. The source may accept the next word only after this return-to-zero exchange is complete.

Only the request and acknowledge levels cross between domains. The data bus is never resynchronized bit by bit. It is safe to sample because it is frozen for the whole time the request is high. The number of synchronizer flops on each control path is a parameter, with a default and minimum of two. Each domain has its own active-low reset.

Top module: `hs_cdc_xfer`

## Requirements
- R1: The accepted word is loaded into the holding register at least one source cycle before the request level rises, and the holding register does not change while the request is high.
- R2: The destination captures the held word only when its synchronized request is high and its acknowledge is low. On that capture it presents the word on `dst_data` and raises the acknowledge.
- R3: `src_ready` falls in the cycle after a word is accepted (`src_valid` and `src_ready` both high at a source edge). It stays low until the synchronized acknowledge has fallen again. Any `src_valid`/`src_data` offered while `src_ready` is low is ignored.
- R4: The source drops the request only after its synchronized copy of the acknowledge is high.
- R5: `dst_valid` is high for exactly one destination cycle per accepted word. Words come out exactly once, in the order they were accepted, and no word is ever produced that was not accepted.
- R6: The destination drops the acknowledge only after its synchronized request is low, so a new transfer starts only after a full return-to-zero cycle. One transfer therefore keeps `src_ready` low for at least five source cycles.
- R7: While each reset is held, and directly after it, `src_ready` is 1, `dst_valid` is 0, and the request, acknowledge and all synchronizer flops are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Source domain clock |
| src_rst_n | input | 1 | Source domain active-low reset |
| src_valid | input | 1 | Source offers a word |
| src_ready | output | 1 | Source side idle and able to accept a word |
| src_data | input | DATA_W | Word offered by the source |
| dst_clk | input | 1 | Destination domain clock |
| dst_rst_n | input | 1 | Destination domain active-low reset |
| dst_valid | output | 1 | One-cycle strobe marking a newly delivered word |
| dst_data | output | DATA_W | Delivered word, valid while `dst_valid` is high and held afterwards |

## Verification
The hardest case to reach is a source that keeps pushing while a handshake is still in flight. In that case `src_valid` stays high and the bus keeps changing with junk values for the whole busy window, so any leak of a non-accepted value or any early reopening of `src_ready` shows up as a wrong or extra word. The bench drives this pressure under three clock ratios: a destination faster than, close to, and much slower than the source. This moves the synchronizer edges through different phase relations. Both resets are also pulsed between runs to confirm that the block restarts cleanly.

// File: rtl/hs_cdc_xfer.sv
module hs_cdc_xfer #(
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              src_clk,
  input  logic              src_rst_n,
  input  logic              src_valid,
  output logic              src_ready,
  input  logic [DATA_W-1:0] src_data,
  input  logic              dst_clk,
  input  logic              dst_rst_n,
  output logic              dst_valid,
  output logic [DATA_W-1:0] dst_data
);

  localparam int NS = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_WAIT_ACK, S_WAIT_REL} src_st_t;

  src_st_t           st_q;
  logic [DATA_W-1:0] hold_q;
  logic              req_q;
  logic              ack_q;
  logic [NS-1:0]     ack_sync_q;
  logic [NS-1:0]     req_sync_q;
  logic              ack_s;
  logic              req_s;

  assign ack_s     = ack_sync_q[NS-1];
  assign req_s     = req_sync_q[NS-1];
  assign src_ready = (st_q == S_IDLE);

  // source domain
  always_ff @(posedge src_clk or negedge src_rst_n) begin
    if (!src_rst_n) ack_sync_q <= '0;
    else            ack_sync_q <= {ack_sync_q[NS-2:0], ack_q};
  end

  always_ff @(posedge src_clk or negedge src_rst_n) begin
    if (!src_rst_n) begin
      st_q   <= S_IDLE;
      req_q  <= 1'b0;
      hold_q <= '0;
    end else begin
      case (st_q)
        S_IDLE:
          if (src_valid) begin
            hold_q <= src_data;
            st_q   <= S_SETUP;
          end
        S_SETUP: begin
          req_q <= 1'b1;
          st_q  <= S_WAIT_ACK;
        end
        S_WAIT_ACK:
          if (ack_s) begin
            req_q <= 1'b0;
            st_q  <= S_WAIT_REL;
          end
        default:
          if (!ack_s) st_q <= S_IDLE;
      endcase
    end
  end

  // destination domain
  always_ff @(posedge dst_clk or negedge dst_rst_n) begin
    if (!dst_rst_n) req_sync_q <= '0;
    else            req_sync_q <= {req_sync_q[NS-2:0], req_q};
  end

  always_ff @(posedge dst_clk or negedge dst_rst_n) begin
    if (!dst_rst_n) begin
      ack_q     <= 1'b0;
      dst_valid <= 1'b0;
      dst_data  <= '0;
    end else begin
      dst_valid <= 1'b0;
      if (req_s && !ack_q) begin
        dst_data  <= hold_q;
        dst_valid <= 1'b1;
        ack_q     <= 1'b1;
      end else if (!req_s && ack_q) begin
        ack_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/hs_cdc_xfer_chk.sv
module hs_cdc_xfer_chk #(
  parameter int DATA_W = 32
) (
  input logic              src_clk,
  input logic              src_rst_n,
  input logic              dst_clk,
  input logic              dst_rst_n,
  input logic              src_ready,
  input logic              req_q,
  input logic              ack_s,
  input logic [DATA_W-1:0] hold_q,
  input logic              ack_q,
  input logic              req_s,
  input logic              dst_valid
);

  AST_REQ_AFTER_LOAD: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    $rose(req_q) |-> (!$past(src_ready) && $stable(hold_q))); // R1

  AST_BUS_FROZEN: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    (req_q && $past(req_q)) |-> $stable(hold_q)); // R1

  AST_READY_LOW_IN_REQ: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    req_q |-> !src_ready); // R3

  AST_HOLD_WHILE_BUSY: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    !src_ready |=> (src_ready || $stable(hold_q))); // R3

  AST_REQ_DROP_ON_ACK: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    $fell(req_q) |-> $past(ack_s)); // R4

  AST_ACK_WITH_CAPTURE: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
    $rose(ack_q) |-> (dst_valid && $past(req_s))); // R2

  AST_STROBE_SINGLE: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
    dst_valid |=> !dst_valid); // R5

  AST_ACK_DROP_ON_REL: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
    $fell(ack_q) |-> !$past(req_s)); // R6

endmodule

bind hs_cdc_xfer hs_cdc_xfer_chk #(.DATA_W(DATA_W)) chk_i (
  .src_clk   (src_clk),
  .src_rst_n (src_rst_n),
  .dst_clk   (dst_clk),
  .dst_rst_n (dst_rst_n),
  .src_ready (src_ready),
  .req_q     (req_q),
  .ack_s     (ack_s),
  .hold_q    (hold_q),
  .ack_q     (ack_q),
  .req_s     (req_s),
  .dst_valid (dst_valid)
);

// File: tb/hs_cdc_xfer_tb_top.sv
`timescale 1ns/1ps
module hs_cdc_xfer_tb_top;
  localparam int DW = 32;
  localparam int WORDS = 20;

  logic          src_clk = 1'b0;
  logic          dst_clk = 1'b0;
  logic          src_rst_n = 1'b0;
  logic          dst_rst_n = 1'b0;
  logic          src_valid = 1'b0;
  logic [DW-1:0] src_data = '0;
  logic          src_ready;
  logic          dst_valid;
  logic [DW-1:0] dst_data;

  real           dst_half = 3.0;
  int            checks = 0;
  int            errors = 0;
  bit            done = 1'b0;
  bit            prev_valid = 1'b0;
  logic [DW-1:0] exp_q[$];

  hs_cdc_xfer #(.DATA_W(DW), .SYNC_STAGES(2)) dut_i (
    .src_clk(src_clk), .src_rst_n(src_rst_n), .src_valid(src_valid),
    .src_ready(src_ready), .src_data(src_data),
    .dst_clk(dst_clk), .dst_rst_n(dst_rst_n),
    .dst_valid(dst_valid), .dst_data(dst_data)
  );

  always #2 src_clk = ~src_clk;
  initial forever #(dst_half) dst_clk = ~dst_clk;

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // reference model on the destination side, compared every destination cycle
  always @(negedge dst_clk) begin
    if (dst_rst_n) begin
      if (dst_valid) begin
        check(exp_q.size() > 0, "R5 word without accepted source", dst_data, '0);
        if (exp_q.size() > 0) begin
          check(dst_data == exp_q[0], "R2 delivered word", dst_data, exp_q[0]);
          void'(exp_q.pop_front());
        end
        check(!prev_valid, "R5 strobe longer than one cycle", {31'd0, prev_valid}, '0);
      end
      prev_valid = dst_valid;
    end else begin
      prev_valid = 1'b0;
    end
  end

  task automatic do_reset();
    src_valid = 1'b0;
    src_rst_n = 1'b0;
    dst_rst_n = 1'b0;
    repeat (3) @(negedge src_clk);
    check(src_ready == 1'b1, "R7 src_ready in reset", {31'd0, src_ready}, 1);
    check(dst_valid == 1'b0, "R7 dst_valid in reset", {31'd0, dst_valid}, 0);
    src_rst_n = 1'b1;
    @(negedge dst_clk);
    dst_rst_n = 1'b1;
    repeat (2) @(negedge src_clk);
    check(src_ready == 1'b1, "R7 src_ready after reset", {31'd0, src_ready}, 1);
    check(dst_valid == 1'b0, "R7 dst_valid after reset", {31'd0, dst_valid}, 0);
  endtask

  task automatic run_phase(input int ph);
    for (int i = 0; i < WORDS; i++) begin
      logic [DW-1:0] w;
      int busy;
      w = (i + 1) * 32'h9E37_79B1 ^ (ph << 28);
      while (!src_ready) @(negedge src_clk);
      src_data  = w;
      src_valid = 1'b1;
      exp_q.push_back(w);
      @(negedge src_clk);
      check(src_ready == 1'b0, "R3 ready drops after accept", {31'd0, src_ready}, 0);
      busy = 1;
      src_data = ~w;
      while (!src_ready) begin
        @(negedge src_clk);
        if (!src_ready) busy++;
        src_data = w ^ busy;
      end
      check(busy >= 5, "R6 full return-to-zero busy time", busy, 5);
      if (i % 3 == 2) begin
        src_valid = 1'b0;
        repeat (i % 5) @(negedge src_clk);
      end
    end
    src_valid = 1'b0;
    for (int t = 0; t < 400 && exp_q.size() > 0; t++) @(negedge src_clk);
    check(exp_q.size() == 0, "R5 all accepted words delivered", exp_q.size(), 0);
    repeat (20) @(negedge src_clk);
    check(!dst_valid && src_ready, "R3 no extra word after idle", {31'd0, dst_valid}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge src_clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    do_reset();
    dst_half = 1.5;
    run_phase(0);
    dst_half = 2.3;
    do_reset();
    run_phase(1);
    dst_half = 6.5;
    do_reset();
    run_phase(2);
    finish_run();
  end
endmodule